// File: doc/BRIEF.md
# SPI Memory Status and Write-Protect Controller

This block holds the status byte of a serial memory and decides whether each array write or status write may go ahead. An SPI front end decodes the opcode and sends one single-cycle strobe per instruction: set the write latch, clear it, write the status, write the array, or read the status. It passes the data byte with a status write and the target address with an array write. The controller also samples the active-low write-protect pin.

Each strobe is taken at a rising clock edge. An accepted array write or status write starts a busy timer that stands in for the internal programming cycle. An accepted array write also gives a one-cycle go pulse to the array. A read-status strobe copies the live status byte into a holding register for the shifter. The front end repeats that strobe for each byte it sends while the instruction stays selected, so every byte it shifts out is current.

The non-volatile bits reset to a parameter value, standing in for stored contents. At most one of the write-latch set, write-latch clear, status-write and array-write strobes is expected in a cycle. If several arrive together, the priority is array write, then status write, then latch clear, then latch set. A read-status strobe may coincide with any of them.

Top module: `spi_sp_ctrl`

## Requirements
- R1: `status_o` bit 7 is the status-lock bit, bits 6..4 always read 0, bits 3..2 are the protect level (bit 3 high), bit 1 is the write latch, and bit 0 is the busy flag.
- R2: After reset, the write latch and the busy flag are 0, `wr_go_o` is 0, and the lock bit and protect level take their values from parameter `NV_INIT` ({lock, level}).
- R3: A write-latch set strobe makes bit 1 read 1 after the next edge. A write-latch clear strobe makes it read 0.
- R4: When the write latch is 0, an array write and a status write both have no effect: no go pulse, the busy flag stays 0, and the status byte is unchanged.
- R5: An accepted array write pulses `wr_go_o` for the one cycle after the strobe edge. The busy flag then reads 1 for exactly `BUSY_CYC` cycles, and the write latch clears in the same cycle the busy flag falls.
- R6: An accepted status write loads the lock bit from data bit 7 and the protect level from data bits 3..2 at the strobe edge. It sets the busy flag for `BUSY_CYC` cycles. Data bits 6..4, 1 and 0 are ignored. Nothing else changes the lock bit or the protect level.
- R7: With an address width of W, level 1 protects addresses whose top two bits are both 1, level 2 protects addresses whose top bit is 1, level 3 protects every address, and level 0 protects none. A refused array write gives no go pulse, leaves the busy flag at 0 and clears the write latch.
- R8: When the lock bit is 1 and `wp_n_i` is 0, a status write is refused. The lock bit and protect level keep their values, the busy flag stays 0, and the write latch clears. With `wp_n_i` high, the same status write is accepted.
- R9: While the busy flag is 1, array writes and status writes are ignored entirely (no go pulse, no status change, write latch untouched). Write-latch set and clear strobes still act.
- R10: A read-status strobe loads `rd_byte_o` with the status byte present at that edge, including while busy. The loaded value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n_i | input | 1 | Active-low write-protect pin |
| wren_i | input | 1 | Write-latch set strobe |
| wrdi_i | input | 1 | Write-latch clear strobe |
| wrsr_i | input | 1 | Status write strobe |
| write_i | input | 1 | Array write strobe |
| rdsr_i | input | 1 | Read-status strobe |
| wr_data_i | input | 8 | Data byte for a status write |
| wr_addr_i | input | ADDR_W | Target address of an array write |
| status_o | output | 8 | Live status byte |
| rd_byte_o | output | 8 | Status byte captured for shifting out |
| wr_go_o | output | 1 | One-cycle pulse that starts an array write |

## Verification
Every strobe is driven for one clock and registered at a single rising edge. The latch bit, protect level, lock bit, go pulse and read byte are therefore all due one cycle after the strobe. The bench samples them at the falling edge that follows that rising edge. The busy flag rises at that same sample. The bench then counts falling-edge samples until the flag drops and compares the count with `BUSY_CYC`. It checks the write latch at the first sample where the busy flag reads 0. For each read-status strobe, the expected byte is the live status captured half a cycle before the strobe's edge.

// File: rtl/spi_sp_pkg.sv
package spi_sp_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WREN,
        OP_WRDI,
        OP_WRSR,
        OP_WRITE
    } op_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] level;
        logic       wel;
        logic       go;
        logic [7:0] rd_byte;
    } ctrl_st_t;

    function automatic logic [7:0] pack_status(input logic       lock,
                                               input logic [1:0] level,
                                               input logic       wel,
                                               input logic       busy);
        return {lock, 3'b000, level, wel, busy};
    endfunction

endpackage

// File: rtl/spi_sp_opdec.sv
module spi_sp_opdec
    import spi_sp_pkg::*;
(
    input  logic wren_i,
    input  logic wrdi_i,
    input  logic wrsr_i,
    input  logic write_i,
    output op_e  op_o
);
    always_comb begin
        if (write_i)     op_o = OP_WRITE;
        else if (wrsr_i) op_o = OP_WRSR;
        else if (wrdi_i) op_o = OP_WRDI;
        else if (wren_i) op_o = OP_WREN;
        else             op_o = OP_NONE;
    end
endmodule

// File: rtl/spi_sp_region.sv
module spi_sp_region #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        level_i,
    output logic              prot_o
);
    localparam int TOP = ADDR_W - 1;

    logic top_one;
    logic top_two;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign top_one = addr_i[TOP];
            assign top_two = addr_i[TOP] & addr_i[TOP-1];
        end else begin : g_narrow
            assign top_one = addr_i[TOP];
            assign top_two = addr_i[TOP];
        end
    endgenerate

    always_comb begin
        case (level_i)
            2'b00:   prot_o = 1'b0;
            2'b01:   prot_o = top_two;
            2'b10:   prot_o = top_one;
            default: prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_sp_timer.sv
module spi_sp_timer #(
    parameter int BUSY_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == ONE);
endmodule

// File: rtl/spi_sp_ctrl.sv
module spi_sp_ctrl
    import spi_sp_pkg::*;
#(
    parameter int         ADDR_W   = 10,
    parameter int         BUSY_CYC = 100,
    parameter logic [2:0] NV_INIT  = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic              write_i,
    input  logic              rdsr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [7:0]        status_o,
    output logic [7:0]        rd_byte_o,
    output logic              wr_go_o
);
    op_e      op;
    ctrl_st_t st_d, st_q;
    logic     prot;
    logic     busy;
    logic     done;
    logic     start;
    logic     hw_lock;

    spi_sp_opdec u_dec (
        .wren_i (wren_i),
        .wrdi_i (wrdi_i),
        .wrsr_i (wrsr_i),
        .write_i(write_i),
        .op_o   (op)
    );

    spi_sp_region #(.ADDR_W(ADDR_W)) u_region (
        .addr_i (wr_addr_i),
        .level_i(st_q.level),
        .prot_o (prot)
    );

    spi_sp_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .busy_o (busy),
        .done_o (done)
    );

    assign status_o = pack_status(st_q.lock, st_q.level, st_q.wel, busy);
    assign hw_lock  = st_q.lock & ~wp_n_i;

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        start   = 1'b0;

        if (rdsr_i)
            st_d.rd_byte = status_o;

        if (done)
            st_d.wel = 1'b0;

        case (op)
            OP_WRITE: begin
                if (!busy) begin
                    if (st_q.wel && !prot) begin
                        start   = 1'b1;
                        st_d.go = 1'b1;
                    end else begin
                        st_d.wel = 1'b0;
                    end
                end
            end
            OP_WRSR: begin
                if (!busy) begin
                    if (st_q.wel && !hw_lock) begin
                        start      = 1'b1;
                        st_d.lock  = wr_data_i[7];
                        st_d.level = wr_data_i[3:2];
                    end else begin
                        st_d.wel = 1'b0;
                    end
                end
            end
            OP_WRDI: st_d.wel = 1'b0;
            OP_WREN: st_d.wel = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock    <= NV_INIT[2];
            st_q.level   <= NV_INIT[1:0];
            st_q.wel     <= 1'b0;
            st_q.go      <= 1'b0;
            st_q.rd_byte <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_byte_o = st_q.rd_byte;
    assign wr_go_o   = st_q.go;
endmodule

// File: rtl/spi_sp_ctrl_chk.sv
module spi_sp_ctrl_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n_i,
    input logic              wrsr_i,
    input logic              write_i,
    input logic              rdsr_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [7:0]        status_o,
    input logic [7:0]        rd_byte_o,
    input logic              wr_go_o
);
    logic [2:0] nv;
    assign nv = {status_o[7], status_o[3:2]};

    AST_BUSY_ONLY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> $past(wrsr_i || write_i)); // R5

    AST_GO_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go_o |-> ($past(status_o[1]) && !$past(status_o[0]))); // R4

    AST_NV_ONLY_BY_WRSR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrsr_i) |-> $stable(nv)); // R6

    AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wrsr_i && status_o[7] && !wp_n_i) |-> $stable(nv)); // R8

    AST_FULL_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (write_i && status_o[3:2] == 2'b11) |=> !wr_go_o); // R7

    AST_BUSY_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (write_i && status_o[0]) |=> !wr_go_o); // R9

    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rdsr_i) |-> (rd_byte_o == $past(status_o))); // R10

    logic unused_addr;
    assign unused_addr = ^wr_addr_i;
endmodule

bind spi_sp_ctrl spi_sp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n_i   (wp_n_i),
    .wrsr_i   (wrsr_i),
    .write_i  (write_i),
    .rdsr_i   (rdsr_i),
    .wr_addr_i(wr_addr_i),
    .status_o (status_o),
    .rd_byte_o(rd_byte_o),
    .wr_go_o  (wr_go_o)
);

// File: tb/spi_sp_ctrl_test.sv
module spi_sp_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int BUSY_CYC   = 5;
    localparam int K_WREN  = 1;
    localparam int K_WRDI  = 2;
    localparam int K_WRSR  = 3;
    localparam int K_WRITE = 4;
    localparam int K_RDSR  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wp_n_i = 1'b1;
    logic              wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0;
    logic              write_i = 1'b0, rdsr_i = 1'b0;
    logic [7:0]        wr_data_i = 8'h00;
    logic [ADDR_W-1:0] wr_addr_i = '0;
    logic [7:0]        status_o, rd_byte_o;
    logic              wr_go_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sp_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC), .NV_INIT(3'b000)) uut (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n_i),
        .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i),
        .write_i(write_i), .rdsr_i(rdsr_i),
        .wr_data_i(wr_data_i), .wr_addr_i(wr_addr_i),
        .status_o(status_o), .rd_byte_o(rd_byte_o), .wr_go_o(wr_go_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input int kind, input logic [7:0] d, input logic [ADDR_W-1:0] a);
        wr_data_i = d;
        wr_addr_i = a;
        wren_i  = (kind == K_WREN);
        wrdi_i  = (kind == K_WRDI);
        wrsr_i  = (kind == K_WRSR);
        write_i = (kind == K_WRITE);
        rdsr_i  = (kind == K_RDSR);
        @(negedge clk);
        wren_i = 1'b0; wrdi_i = 1'b0; wrsr_i = 1'b0; write_i = 1'b0; rdsr_i = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (status_o[0] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic bit is_prot(input int lvl, input int a);
        return (lvl == 3) || (lvl == 2 && a >= 8) || (lvl == 1 && a >= 12);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R2 reset status", status_o, 8'h00);
        check("R2 reset go", wr_go_o, 0);

        do_op(K_WREN, 8'h00, '0);
        check("R3 latch set", status_o, 8'h02);
        do_op(K_WRDI, 8'h00, '0);
        check("R3 latch clear", status_o, 8'h00);

        do_op(K_WRITE, 8'h00, '0);
        check("R4 write without latch go", wr_go_o, 0);
        check("R4 write without latch status", status_o, 8'h00);
        do_op(K_WRSR, 8'h8C, '0);
        check("R4 wrsr without latch status", status_o, 8'h00);

        do_op(K_WREN, 8'h00, '0);
        do_op(K_WRSR, 8'hFC, '0);
        check("R1 R6 status layout while busy", status_o, 8'h8F);
        wait_idle(n);
        check("R6 busy length", n, BUSY_CYC);
        check("R6 latch cleared at end", status_o, 8'h8C);

        wp_n_i = 1'b0;
        do_op(K_WREN, 8'h00, '0);
        check("R8 latch set under lock", status_o, 8'h8E);
        do_op(K_WRSR, 8'h00, '0);
        check("R8 locked wrsr refused", status_o, 8'h8C);
        wp_n_i = 1'b1;
        do_op(K_WREN, 8'h00, '0);
        do_op(K_WRSR, 8'h00, '0);
        check("R8 unlocked wrsr accepted", status_o, 8'h03);
        wait_idle(n);
        check("R8 after unlock", status_o, 8'h00);

        for (int lvl = 0; lvl < 4; lvl++) begin
            do_op(K_WREN, 8'h00, '0);
            do_op(K_WRSR, 8'(lvl << 2), '0);
            wait_idle(n);
            for (int a = 0; a < 16; a++) begin
                bit ok;
                ok = !is_prot(lvl, a);
                do_op(K_WREN, 8'h00, '0);
                do_op(K_WRITE, 8'h00, ADDR_W'(a));
                check("R7 go vs region", wr_go_o, int'(ok));
                if (ok) begin
                    check("R5 busy after accept", status_o[0], 1);
                    wait_idle(n);
                    check("R5 busy length", n, BUSY_CYC);
                    check("R5 latch cleared", status_o, lvl << 2);
                    check("R5 go is one cycle", wr_go_o, 0);
                end else begin
                    check("R7 refused write status", status_o, lvl << 2);
                end
            end
        end

        do_op(K_WREN, 8'h00, '0);
        do_op(K_WRSR, 8'h00, '0);
        wait_idle(n);

        do_op(K_WREN, 8'h00, '0);
        do_op(K_WRITE, 8'h00, '0);
        check("R9 first write accepted", wr_go_o, 1);
        do_op(K_WREN, 8'h00, '0);
        check("R9 latch set while busy", status_o[1], 1);
        do_op(K_WRITE, 8'h00, 4'h1);
        check("R9 write ignored go", wr_go_o, 0);
        check("R9 write ignored latch", status_o[1], 1);
        do_op(K_WRSR, 8'h8C, '0);
        check("R9 wrsr ignored", status_o, 8'h03);
        wait_idle(n);
        check("R9 end of cycle", status_o, 8'h00);

        do_op(K_WREN, 8'h00, '0);
        do_op(K_WRITE, 8'h00, '0);
        for (int i = 0; i < 3; i++) begin
            snap = status_o;
            do_op(K_RDSR, 8'h00, '0);
            check("R10 read while busy", rd_byte_o, snap);
        end
        wait_idle(n);
        snap = status_o;
        do_op(K_RDSR, 8'h00, '0);
        check("R10 read idle", rd_byte_o, snap);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule